// File: doc/BRIEF.md
# Configurable Logic Cell Register

This block is the output stage of one programmable logic cell. It receives a sum-of-products result and one additional product term, combines them into a single logic value, and passes that value either straight through or into a storage element. All choices are made by static configuration inputs:
- whether the extra product term is XORed in;
- whether the result is inverted;
- which storage type is used;
- which clock drives it, on which edge or edges;
- whether a clock enable applies;
- which sources drive the asynchronous set and reset.

The cell has two outputs. `cell_o` is the stored or combinational result. `node_o` is the signal fed back into the fabric. In input-register mode, the storage element samples the cell's pin instead of the logic value. The logic value then still reaches the fabric through `node_o`, so it remains usable as an internal node.

Top module: `cfg_cell_reg`

## Requirements
- R1: The logic value is `sop_i ^ (cfg_xor_i & xpt_i)`, inverted when `cfg_inv_i`=1. With `cfg_store_i`=3 (bypass), `cell_o` shows this value combinationally.
- R2: With `cfg_store_i`=0 (D flip-flop), `cell_o` takes the data value present at the active edge of the effective clock. It does not change between edges.
- R3: In D mode with `cfg_ce_en_i`=1 and `ce_i`=0, clock edges leave `cell_o` unchanged. With `cfg_ce_en_i`=0, `ce_i` has no effect.
- R4: With `cfg_store_i`=1 (T flip-flop), each active edge inverts `cell_o` when the data value is 1, and leaves it unchanged when the data value is 0.
- R5: With `cfg_store_i`=2 (latch), `cell_o` follows the data value while the effective clock is high, and holds while it is low.
- R6: `cfg_clk_sel_i` chooses the clock source. Values 0..2 select `gclk_i[0..2]`, 3 selects `shr_clk_i` and 4 selects `loc_clk_i`. Edges on the unselected clocks have no effect.
- R7: With `cfg_clk_inv_i`=1, the effective clock is the inverse of the selected clock, so the falling edge of the source is the active edge.
- R8: With `cfg_dual_i`=1 in D or T mode, the element updates on both edges of the effective clock. `cell_o` reflects the most recent edge.
- R9: `cfg_set_sel_i` and `cfg_rst_sel_i` each choose an asynchronous source. The codes are 0 none, 1 `gsr_i`, 2 shared term (`shr_set_i` / `shr_rst_i`) and 3 local term (`loc_set_i` / `loc_rst_i`). An active selected set forces `cell_o` to 1 and an active selected reset forces it to 0, both without a clock. Unselected sources have no effect.
- R10: When the selected set and the selected reset are active together, `cell_o` is 0.
- R11: With `cfg_in_reg_i`=1 and a non-bypass store, the storage element uses `pin_i` as its data and `node_o` shows the logic value of R1. In all other cases `node_o` equals `cell_o`.
- R12: While the selected reset is active in a non-bypass store, `cell_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk_i | input | NUM_GCLK | Global clocks |
| shr_clk_i | input | 1 | Shared control-term clock |
| loc_clk_i | input | 1 | Local product-term clock |
| gsr_i | input | 1 | Global set/reset line |
| shr_set_i | input | 1 | Shared control-term set |
| shr_rst_i | input | 1 | Shared control-term reset |
| loc_set_i | input | 1 | Local product-term set |
| loc_rst_i | input | 1 | Local product-term reset |
| sop_i | input | 1 | Sum-of-products result |
| xpt_i | input | 1 | Extra single product term |
| pin_i | input | 1 | Cell pin input for input-register mode |
| ce_i | input | 1 | Clock enable |
| cfg_xor_i | input | 1 | Enable XOR with `xpt_i` |
| cfg_inv_i | input | 1 | Invert logic value |
| cfg_store_i | input | 2 | Store type: 0 D, 1 T, 2 latch, 3 bypass |
| cfg_clk_sel_i | input | CLK_SEL_W | Clock source select |
| cfg_clk_inv_i | input | 1 | Clock polarity invert |
| cfg_dual_i | input | 1 | Dual-edge update |
| cfg_ce_en_i | input | 1 | Use clock enable (D mode) |
| cfg_in_reg_i | input | 1 | Store samples `pin_i` |
| cfg_set_sel_i | input | 2 | Asynchronous set source |
| cfg_rst_sel_i | input | 2 | Asynchronous reset source |
| cell_o | output | 1 | Cell result |
| node_o | output | 1 | Feedback node |

## Verification
The clocked assertions sample on `gclk_i[0]` and assume that the configuration inputs, and any set source, stay constant across the two edges they compare. They also assume that no asynchronous pulse arrives between those edges. The bench follows these assumptions. It changes the configuration only between scenarios and drives data on the inactive half of the clock. It pulses set and reset only in scenarios that clock the cell from a manually driven source rather than `gclk_i[0]`.

// File: rtl/cell_cfg_pkg.sv
package cell_cfg_pkg;
  typedef enum logic [1:0] {
    ST_DFF    = 2'd0,
    ST_TFF    = 2'd1,
    ST_LATCH  = 2'd2,
    ST_BYPASS = 2'd3
  } store_e;

  typedef enum logic [1:0] {
    AS_NONE   = 2'd0,
    AS_GLOBAL = 2'd1,
    AS_SHARED = 2'd2,
    AS_LOCAL  = 2'd3
  } async_src_e;

  // R1: sum-of-products XOR optional product term, then polarity
  function automatic logic cell_value(input logic sop, input logic xpt,
                                      input logic xor_en, input logic inv);
    return sop ^ (xor_en & xpt) ^ inv;
  endfunction

  // T-type next state versus D-type next state
  function automatic logic next_state(input store_e mode, input logic q,
                                      input logic d);
    return (mode == ST_TFF) ? (q ^ d) : d;
  endfunction
endpackage

// File: rtl/cell_clk_pick.sv
module cell_clk_pick #(
  parameter int NUM_GCLK = 3,
  parameter int SEL_W    = 3
) (
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                shr_clk_i,
  input  logic                loc_clk_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                inv_i,
  output logic                clk_o
);
  localparam int NSRC = NUM_GCLK + 2;

  logic [NSRC-1:0] src;
  logic            raw;

  genvar g;
  generate
    for (g = 0; g < NUM_GCLK; g++) begin : g_glob
      assign src[g] = gclk_i[g];
    end
  endgenerate
  assign src[NUM_GCLK]   = shr_clk_i;
  assign src[NUM_GCLK+1] = loc_clk_i;

  always_comb begin
    raw = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (sel_i == SEL_W'(k)) raw = src[k];
    end
  end

  assign clk_o = raw ^ inv_i;
endmodule

// File: rtl/cell_async_pick.sv
module cell_async_pick
  import cell_cfg_pkg::*;
(
  input  logic       glob_i,
  input  logic       shr_i,
  input  logic       loc_i,
  input  logic [1:0] sel_i,
  output logic       act_o
);
  always_comb begin
    unique case (async_src_e'(sel_i))
      AS_GLOBAL: act_o = glob_i;
      AS_SHARED: act_o = shr_i;
      AS_LOCAL:  act_o = loc_i;
      default:   act_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cell_store.sv
module cell_store
  import cell_cfg_pkg::*;
(
  input  logic   clk_i,
  input  logic   dual_i,
  input  store_e mode_i,
  input  logic   ce_en_i,
  input  logic   ce_i,
  input  logic   d_i,
  input  logic   set_i,
  input  logic   rst_i,
  output logic   q_o
);
  logic rise_q, fall_q, lat_q;
  logic nxt, hold;

  assign hold = (mode_i == ST_DFF) && ce_en_i && !ce_i;
  assign nxt  = next_state(mode_i, q_o, d_i);

  // reset has priority over set in every storage path (R10)
  always_ff @(posedge clk_i or posedge rst_i or posedge set_i) begin
    if (rst_i)      rise_q <= 1'b0;
    else if (set_i) rise_q <= 1'b1;
    else if (!hold) rise_q <= nxt;
  end

  always_ff @(negedge clk_i or posedge rst_i or posedge set_i) begin
    if (rst_i)      fall_q <= 1'b0;
    else if (set_i) fall_q <= 1'b1;
    else if (!hold) fall_q <= nxt;
  end

  always_latch begin
    if (rst_i)                             lat_q <= 1'b0;
    else if (set_i)                        lat_q <= 1'b1;
    else if (clk_i && mode_i == ST_LATCH)  lat_q <= d_i;
  end

  always_comb begin
    if (mode_i == ST_LATCH)     q_o = lat_q;
    else if (dual_i && !clk_i)  q_o = fall_q;
    else                        q_o = rise_q;
  end
endmodule

// File: rtl/cfg_cell_reg.sv
module cfg_cell_reg
  import cell_cfg_pkg::*;
#(
  parameter int NUM_GCLK  = 3,
  parameter int CLK_SEL_W = 3
) (
  input  logic [NUM_GCLK-1:0]  gclk_i,
  input  logic                 shr_clk_i,
  input  logic                 loc_clk_i,
  input  logic                 gsr_i,
  input  logic                 shr_set_i,
  input  logic                 shr_rst_i,
  input  logic                 loc_set_i,
  input  logic                 loc_rst_i,
  input  logic                 sop_i,
  input  logic                 xpt_i,
  input  logic                 pin_i,
  input  logic                 ce_i,
  input  logic                 cfg_xor_i,
  input  logic                 cfg_inv_i,
  input  logic [1:0]           cfg_store_i,
  input  logic [CLK_SEL_W-1:0] cfg_clk_sel_i,
  input  logic                 cfg_clk_inv_i,
  input  logic                 cfg_dual_i,
  input  logic                 cfg_ce_en_i,
  input  logic                 cfg_in_reg_i,
  input  logic [1:0]           cfg_set_sel_i,
  input  logic [1:0]           cfg_rst_sel_i,
  output logic                 cell_o,
  output logic                 node_o
);
  store_e mode;
  logic   v_w;
  logic   din_w;
  logic   clk_eff;
  logic   set_act;
  logic   rst_act;
  logic   q_w;
  logic   bypass;

  assign mode   = store_e'(cfg_store_i);
  assign bypass = (mode == ST_BYPASS);
  assign v_w    = cell_value(sop_i, xpt_i, cfg_xor_i, cfg_inv_i);
  assign din_w  = cfg_in_reg_i ? pin_i : v_w;

  cell_clk_pick #(.NUM_GCLK(NUM_GCLK), .SEL_W(CLK_SEL_W)) u_clk (
    .gclk_i    (gclk_i),
    .shr_clk_i (shr_clk_i),
    .loc_clk_i (loc_clk_i),
    .sel_i     (cfg_clk_sel_i),
    .inv_i     (cfg_clk_inv_i),
    .clk_o     (clk_eff)
  );

  cell_async_pick u_set (
    .glob_i (gsr_i),
    .shr_i  (shr_set_i),
    .loc_i  (loc_set_i),
    .sel_i  (cfg_set_sel_i),
    .act_o  (set_act)
  );

  cell_async_pick u_rst (
    .glob_i (gsr_i),
    .shr_i  (shr_rst_i),
    .loc_i  (loc_rst_i),
    .sel_i  (cfg_rst_sel_i),
    .act_o  (rst_act)
  );

  cell_store u_store (
    .clk_i   (clk_eff),
    .dual_i  (cfg_dual_i),
    .mode_i  (mode),
    .ce_en_i (cfg_ce_en_i),
    .ce_i    (ce_i),
    .d_i     (din_w),
    .set_i   (set_act),
    .rst_i   (rst_act),
    .q_o     (q_w)
  );

  assign cell_o = bypass ? v_w : q_w;
  assign node_o = (cfg_in_reg_i && !bypass) ? v_w : cell_o;
endmodule

// File: rtl/cell_chk.sv
module cell_chk #(
  parameter int SEL_W = 3
) (
  input logic             gclk0,
  input logic             rst_act,
  input logic             set_act,
  input logic [1:0]       store,
  input logic [SEL_W-1:0] clk_sel,
  input logic             clk_inv,
  input logic             dual,
  input logic             ce_en,
  input logic             ce,
  input logic             in_reg,
  input logic             v_w,
  input logic             cell_o,
  input logic             node_o
);
  logic base0, cond_d, cond_hold, cond_t, quiet;

  assign base0     = (clk_sel == '0) && !clk_inv && !dual;
  assign cond_d    = base0 && store == 2'd0 && !in_reg && !(ce_en && !ce);
  assign cond_hold = base0 && store == 2'd0 && ce_en && !ce;
  assign cond_t    = base0 && store == 2'd1 && !in_reg;
  assign quiet     = !rst_act && !set_act;

  assert_dff_capture_R2: assert property (@(posedge gclk0) disable iff (rst_act)
    (cond_d && $past(cond_d) && $past(quiet) && !set_act) |-> cell_o == $past(v_w));

  assert_ce_hold_R3: assert property (@(posedge gclk0) disable iff (rst_act)
    (cond_hold && $past(cond_hold) && $past(quiet) && !set_act) |-> cell_o == $past(cell_o));

  assert_toggle_R4: assert property (@(posedge gclk0) disable iff (rst_act)
    (cond_t && $past(cond_t) && $past(quiet) && !set_act) |-> cell_o == ($past(cell_o) ^ $past(v_w)));

  assert_reset_low_R12: assert property (@(posedge gclk0)
    (rst_act && store != 2'd3) |-> !cell_o);

  assert_bypass_node_R11: assert property (@(posedge gclk0) disable iff (rst_act)
    (store == 2'd3) |-> node_o == cell_o);
endmodule

bind cfg_cell_reg cell_chk #(.SEL_W(CLK_SEL_W)) u_chk (
  .gclk0   (gclk_i[0]),
  .rst_act (rst_act),
  .set_act (set_act),
  .store   (cfg_store_i),
  .clk_sel (cfg_clk_sel_i),
  .clk_inv (cfg_clk_inv_i),
  .dual    (cfg_dual_i),
  .ce_en   (cfg_ce_en_i),
  .ce      (ce_i),
  .in_reg  (cfg_in_reg_i),
  .v_w     (v_w),
  .cell_o  (cell_o),
  .node_o  (node_o)
);

// File: tb/test_cfg_cell_reg.sv
module test_cfg_cell_reg;
  localparam int CLK_PERIOD = 10;

  logic [2:0] gclk;
  logic shr_clk, loc_clk;
  logic gsr, shr_set, shr_rst, loc_set, loc_rst;
  logic sop, xpt, pin, ce;
  logic cfg_xor, cfg_inv, cfg_clk_inv, cfg_dual, cfg_ce_en, cfg_in_reg;
  logic [1:0] cfg_store, cfg_set_sel, cfg_rst_sel;
  logic [2:0] cfg_clk_sel;
  logic cell_o, node_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic cur;

  cfg_cell_reg i_cfg_cell_reg (
    .gclk_i(gclk), .shr_clk_i(shr_clk), .loc_clk_i(loc_clk),
    .gsr_i(gsr), .shr_set_i(shr_set), .shr_rst_i(shr_rst),
    .loc_set_i(loc_set), .loc_rst_i(loc_rst),
    .sop_i(sop), .xpt_i(xpt), .pin_i(pin), .ce_i(ce),
    .cfg_xor_i(cfg_xor), .cfg_inv_i(cfg_inv), .cfg_store_i(cfg_store),
    .cfg_clk_sel_i(cfg_clk_sel), .cfg_clk_inv_i(cfg_clk_inv),
    .cfg_dual_i(cfg_dual), .cfg_ce_en_i(cfg_ce_en), .cfg_in_reg_i(cfg_in_reg),
    .cfg_set_sel_i(cfg_set_sel), .cfg_rst_sel_i(cfg_rst_sel),
    .cell_o(cell_o), .node_o(node_o)
  );

  initial gclk[0] = 1'b0;
  always #(CLK_PERIOD/2) gclk[0] = ~gclk[0];

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input string tag, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // manual clock level: 1 gclk1, 2 gclk2, 3 shared, 4 local
  task automatic set_clk(input int idx, input logic lvl);
    case (idx)
      1: gclk[1] = lvl;
      2: gclk[2] = lvl;
      3: shr_clk = lvl;
      default: loc_clk = lvl;
    endcase
    #2;
  endtask

  task automatic pulse(input int idx);
    set_clk(idx, 1'b1);
    set_clk(idx, 1'b0);
  endtask

  task automatic edge0();
    @(posedge gclk[0]); #1;
  endtask

  task automatic t_reset();
    check("R12 reset holds 0", cell_o, 1'b0);
    edge0();
    check("R12 reset holds 0 across edge", cell_o, 1'b0);
    gsr = 1'b0; #1;
  endtask

  task automatic t_logic();
    logic e;
    cfg_store = 2'd3;
    for (int k = 0; k < 16; k++) begin
      {sop, xpt, cfg_xor, cfg_inv} = 4'(k);
      #1;
      e = (cfg_xor && xpt) ? !sop : sop;
      if (cfg_inv) e = !e;
      check("R1 logic value", cell_o, e);
      check("R11 node equals cell", node_o, cell_o);
    end
    cfg_xor = 0; cfg_inv = 0; xpt = 0;
  endtask

  task automatic t_dff();
    cfg_store = 2'd0; cfg_clk_sel = 3'd0;
    for (int k = 0; k < 4; k++) begin
      @(negedge gclk[0]);
      cur = cell_o;
      sop = (k % 2 == 0); #1;
      check("R2 no change between edges", cell_o, cur);
      edge0();
      check("R2 capture at edge", cell_o, (k % 2 == 0));
    end
  endtask

  task automatic t_ce();
    cfg_ce_en = 1; ce = 0;
    @(negedge gclk[0]); cur = cell_o; sop = !cur;
    edge0(); check("R3 hold with enable low", cell_o, cur);
    @(negedge gclk[0]); ce = 1;
    edge0(); check("R3 update with enable high", cell_o, !cur);
    @(negedge gclk[0]); cfg_ce_en = 0; ce = 0; sop = cur;
    edge0(); check("R3 enable ignored when unused", cell_o, cur);
  endtask

  task automatic t_tff();
    @(negedge gclk[0]); cfg_store = 2'd1; sop = 1;
    edge0();
    for (int k = 0; k < 3; k++) begin
      cur = cell_o;
      edge0(); check("R4 toggle on 1", cell_o, !cur);
    end
    @(negedge gclk[0]); sop = 0; cur = cell_o;
    edge0(); check("R4 hold on 0", cell_o, cur);
  endtask

  task automatic t_clk_sel();
    cfg_store = 2'd0;
    for (int s = 1; s <= 4; s++) begin
      cfg_clk_sel = 3'(s); #2;
      cur = cell_o; sop = !cur; #1;
      for (int o = 1; o <= 4; o++) if (o != s) pulse(o);
      check("R6 other clocks ignored", cell_o, cur);
      pulse(s);
      check("R6 selected clock captures", cell_o, !cur);
    end
  endtask

  task automatic t_polarity();
    cfg_clk_sel = 3'd1; cfg_clk_inv = 1; #2;
    cur = cell_o; sop = !cur; #1;
    set_clk(1, 1'b1);
    check("R7 source rise inactive", cell_o, cur);
    set_clk(1, 1'b0);
    check("R7 source fall active", cell_o, !cur);
    cfg_clk_inv = 0; #2;
  endtask

  task automatic t_dual();
    cfg_clk_sel = 3'd3; cfg_dual = 1; #2;
    sop = 1; set_clk(3, 1'b1);
    check("R8 rising edge update", cell_o, 1'b1);
    sop = 0; #1;
    check("R8 stable while high", cell_o, 1'b1);
    set_clk(3, 1'b0);
    check("R8 falling edge update", cell_o, 1'b0);
    sop = 1; set_clk(3, 1'b1);
    check("R8 next rising edge", cell_o, 1'b1);
    set_clk(3, 1'b0);
    cfg_dual = 0; #2;
  endtask

  task automatic t_latch();
    cfg_store = 2'd2; cfg_clk_sel = 3'd4;
    set_clk(4, 1'b1);
    sop = 1; #1; check("R5 transparent 1", cell_o, 1'b1);
    sop = 0; #1; check("R5 transparent 0", cell_o, 1'b0);
    set_clk(4, 1'b0);
    sop = 1; #1; check("R5 opaque hold", cell_o, 1'b0);
  endtask

  task automatic t_async();
    cfg_store = 2'd0; cfg_clk_sel = 3'd1; sop = 0; #2;
    cfg_set_sel = 2'd2; cfg_rst_sel = 2'd3; #1;
    shr_set = 1; #1; check("R9 shared set", cell_o, 1'b1);
    gsr = 1; #1; check("R9 unselected global ignored", cell_o, 1'b1);
    gsr = 0;
    loc_rst = 1; #1; check("R10 reset wins over set", cell_o, 1'b0);
    pulse(1); check("R10 reset wins at clock", cell_o, 1'b0);
    shr_set = 0; #1; loc_rst = 0; #1;
    cfg_set_sel = 2'd3; cfg_rst_sel = 2'd0; #1;
    loc_set = 1; #1; check("R9 local set", cell_o, 1'b1);
    gsr = 1; #1; check("R9 no reset source selected", cell_o, 1'b1);
    loc_set = 0; #1;
    cfg_rst_sel = 2'd1; #1; check("R9 global reset", cell_o, 1'b0);
    gsr = 0; #1;
  endtask

  task automatic t_inreg();
    cfg_store = 2'd0; cfg_clk_sel = 3'd1; cfg_in_reg = 1;
    sop = 1; pin = 0; #1;
    pulse(1);
    check("R11 store samples pin", cell_o, 1'b0);
    check("R11 node shows logic value", node_o, 1'b1);
    pin = 1; #1;
    check("R11 pin needs edge", cell_o, 1'b0);
    pulse(1);
    check("R11 pin captured", cell_o, 1'b1);
    sop = 0; #1;
    check("R11 node follows logic", node_o, 1'b0);
    check("R11 cell keeps pin value", cell_o, 1'b1);
    cfg_in_reg = 0; #1;
  endtask

  initial begin
    gclk[2:1] = 2'b00; shr_clk = 0; loc_clk = 0;
    gsr = 1; shr_set = 0; shr_rst = 0; loc_set = 0; loc_rst = 0;
    sop = 0; xpt = 0; pin = 0; ce = 0;
    cfg_xor = 0; cfg_inv = 0; cfg_store = 2'd0; cfg_clk_sel = 3'd0;
    cfg_clk_inv = 0; cfg_dual = 0; cfg_ce_en = 0; cfg_in_reg = 0;
    cfg_set_sel = 2'd0; cfg_rst_sel = 2'd1;
    #3;
    t_reset();
    t_logic();
    t_dff();
    t_ce();
    t_tff();
    t_clk_sel();
    t_polarity();
    t_dual();
    t_latch();
    t_async();
    t_inreg();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule